// File: doc/BRIEF.md
# DRAM Rank Pin Drive and Clock-Enable Gate

This block sits between a memory controller and the pad ring. It decides, for every rank, whether the clock-enable and chip-select outputs are driven or released to high impedance, what level they carry, and whether the input receivers for that rank are powered. From reset until software writes an initialization-complete bit, clock-enable stays low on every rank. Every rank is assumed to be fitted until software supplies a mask and an enable that together say otherwise. Once released, clock-enable follows the power controller's per-rank request. While a self-refresh request is present, clock-enable is held low on all ranks, whatever else is asked.

The fitted-rank mask and the release enable are captured into internal registers. Before initialization completes they are captured on every clock. After that, a rank's copy is refreshed only while that rank reports idle, so that a pin is never switched off under traffic. A rank that is marked unfitted with release enabled has its clock-enable and chip-select undriven. Its input receiver is disabled, and its read-valid input is forced inactive, so noise on floating wires cannot reach the core.

Top module: `rank_pin_gate`

## Requirements
- R1: While `initDone` reads 0, including during reset, `ckeOut` is 0 on every rank.
- R2: While reset is asserted, `ckeOe`, `csOe` and `rxEn` are all ones, whatever `popMask` and `triEn` carry.
- R3: A rank with its `popMask` bit at 0 stays driven (`ckeOe`, `csOe`, `rxEn` at 1) while `triEn` is 0.
- R4: A rank whose captured `popMask` bit is 0 with captured `triEn` at 1 has `ckeOe` and `csOe` at 0, `ckeOut` at 0 and `csOut` at 1. A capture taken at a clock edge shows on the outputs directly after that edge.
- R5: A rank that is released has `rxEn` at 0 and `rdValidOut` at 0 whatever its `rdValidIn` bit is. A driven rank passes `rdValidIn` through unchanged.
- R6: While `selfRefresh` is 1, `ckeOut` is 0 on every rank in the same cycle, even after initialization and even in the cycle that `initDone` first becomes 1.
- R7: A cycle with `initWr` at 1 loads `initWrData` into `initDone`, visible after that clock edge. Without a write, `initDone` holds its value, and reset returns it to 0.
- R8: While `initDone` is 1, a rank whose `rankIdle` bit is 0 ignores changes on `popMask` and `triEn`. A rank whose `rankIdle` bit is 1 takes them at the next edge.
- R9: For a driven rank, `csOut` equals its `csReq` bit, and, once `initDone` is 1 and `selfRefresh` is 0, `ckeOut` equals its `ckeReq` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initWr | input | 1 | Software write strobe for the init-done bit |
| initWrData | input | 1 | Value written to the init-done bit |
| popMask | input | NUM_RANKS | Fitted ranks, 1 = fitted |
| triEn | input | 1 | Permits releasing the pins of unfitted ranks |
| rankIdle | input | NUM_RANKS | Rank has no outstanding traffic |
| ckeReq | input | NUM_RANKS | Clock-enable level requested by the power controller |
| csReq | input | NUM_RANKS | Chip-select level requested (active low) |
| selfRefresh | input | 1 | Self-refresh in progress, forces clock-enable low |
| rdValidIn | input | NUM_RANKS | Read-valid from each rank's receive path |
| ckeOut | output | NUM_RANKS | Clock-enable pin level |
| ckeOe | output | NUM_RANKS | Clock-enable output enable |
| csOut | output | NUM_RANKS | Chip-select pin level |
| csOe | output | NUM_RANKS | Chip-select output enable |
| rxEn | output | NUM_RANKS | Input receiver enable per rank |
| rdValidOut | output | NUM_RANKS | Gated read-valid toward the core |
| initDone | output | 1 | Readback of the init-done bit |

## Verification
The software release of clock-enable and a self-refresh request can land on the same clock. The bench writes `initDone` in a cycle where `selfRefresh` is already high and then checks that `initDone` reads 1 while `ckeOut` stays 0 until self-refresh drops. A second collision is a mask change that arrives while one rank is busy and the others are idle. There, the bench expects only the idle ranks to release their pins at that edge, and expects the busy rank to follow once it reports idle.

// File: rtl/rank_pin_pkg.sv
package rank_pin_pkg;
  localparam int MAX_RANKS = 4;

  typedef struct packed {
    logic [MAX_RANKS-1:0] sampleEn;
    logic                 ckeRelease;
  } pinCtl_t;
endpackage

// File: rtl/rank_pin_ctrl.sv
module rank_pin_ctrl
  import rank_pin_pkg::*;
#(
  parameter int NUM_RANKS = MAX_RANKS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 initWr,
  input  logic                 initWrData,
  input  logic                 selfRefresh,
  input  logic [NUM_RANKS-1:0] rankIdle,
  output logic                 initDone,
  output pinCtl_t              ctl
);
  logic initDoneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       initDoneQ <= 1'b0;
    else if (initWr) initDoneQ <= initWrData;
  end

  always_comb begin
    ctl = '0;
    ctl.sampleEn[NUM_RANKS-1:0] = {NUM_RANKS{~initDoneQ}} | rankIdle;
    ctl.ckeRelease = initDoneQ & ~selfRefresh;
  end

  assign initDone = initDoneQ;

  // R7: without a write the bit keeps its value
  p_init_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!initWr) |=> (initDone == $past(initDone)));

  // R7: a write lands after the edge
  p_init_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    initWr |=> (initDone == $past(initWrData)));
endmodule

// File: rtl/rank_pin_dp.sv
module rank_pin_dp
  import rank_pin_pkg::*;
#(
  parameter int NUM_RANKS = MAX_RANKS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pinCtl_t              ctl,
  input  logic [NUM_RANKS-1:0] popMask,
  input  logic                 triEn,
  input  logic [NUM_RANKS-1:0] ckeReq,
  input  logic [NUM_RANKS-1:0] csReq,
  input  logic [NUM_RANKS-1:0] rdValidIn,
  output logic [NUM_RANKS-1:0] ckeOut,
  output logic [NUM_RANKS-1:0] ckeOe,
  output logic [NUM_RANKS-1:0] csOut,
  output logic [NUM_RANKS-1:0] csOe,
  output logic [NUM_RANKS-1:0] rxEn,
  output logic [NUM_RANKS-1:0] rdValidOut
);
  logic [NUM_RANKS-1:0] popQ;
  logic [NUM_RANKS-1:0] triQ;
  logic [NUM_RANKS-1:0] rankOff;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        popQ[r] <= 1'b1;
        triQ[r] <= 1'b0;
      end else if (ctl.sampleEn[r]) begin
        popQ[r] <= popMask[r];
        triQ[r] <= triEn;
      end
    end

    assign rankOff[r]    = triQ[r] & ~popQ[r];
    assign ckeOe[r]      = ~rankOff[r];
    assign csOe[r]       = ~rankOff[r];
    assign rxEn[r]       = ~rankOff[r];
    assign ckeOut[r]     = ctl.ckeRelease & ckeReq[r] & ~rankOff[r];
    assign csOut[r]      = rankOff[r] | csReq[r];
    assign rdValidOut[r] = rdValidIn[r] & ~rankOff[r];

    // R5: nothing reaches the core from a disabled receiver
    p_rx_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
      !rxEn[r] |-> !rdValidOut[r]);

    // R4: a capture takes effect right after the edge
    p_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
      ctl.sampleEn[r] |=> (ckeOe[r] == !($past(triEn) && !$past(popMask[r]))));
  end
endmodule

// File: rtl/rank_pin_gate.sv
module rank_pin_gate
  import rank_pin_pkg::*;
#(
  parameter int NUM_RANKS = MAX_RANKS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 initWr,
  input  logic                 initWrData,
  input  logic [NUM_RANKS-1:0] popMask,
  input  logic                 triEn,
  input  logic [NUM_RANKS-1:0] rankIdle,
  input  logic [NUM_RANKS-1:0] ckeReq,
  input  logic [NUM_RANKS-1:0] csReq,
  input  logic                 selfRefresh,
  input  logic [NUM_RANKS-1:0] rdValidIn,
  output logic [NUM_RANKS-1:0] ckeOut,
  output logic [NUM_RANKS-1:0] ckeOe,
  output logic [NUM_RANKS-1:0] csOut,
  output logic [NUM_RANKS-1:0] csOe,
  output logic [NUM_RANKS-1:0] rxEn,
  output logic [NUM_RANKS-1:0] rdValidOut,
  output logic                 initDone
);
  pinCtl_t ctl;

  rank_pin_ctrl #(.NUM_RANKS(NUM_RANKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .initWr(initWr), .initWrData(initWrData),
    .selfRefresh(selfRefresh), .rankIdle(rankIdle),
    .initDone(initDone), .ctl(ctl)
  );

  rank_pin_dp #(.NUM_RANKS(NUM_RANKS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .popMask(popMask), .triEn(triEn),
    .ckeReq(ckeReq), .csReq(csReq), .rdValidIn(rdValidIn),
    .ckeOut(ckeOut), .ckeOe(ckeOe), .csOut(csOut), .csOe(csOe),
    .rxEn(rxEn), .rdValidOut(rdValidOut)
  );

  // R1: no clock-enable before software releases it
  p_cke_low_uninit_r1: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (ckeOut == '0));

  // R6: self-refresh keeps every clock-enable low
  p_sr_cke_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |-> (ckeOut == '0));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    // R8: a busy rank keeps its drive state once initialized
    p_busy_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
      (initDone && !rankIdle[r]) |=> $stable(ckeOe[r]));
  end
endmodule

// File: tb/rank_pin_gate_tb.sv
`timescale 1ns/1ps
module rank_pin_gate_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initWr = 1'b0, initWrData = 1'b0, triEn = 1'b0, selfRefresh = 1'b0;
  logic [N-1:0] popMask = '1, rankIdle = '1, ckeReq = '0, csReq = '1, rdValidIn = '0;
  logic [N-1:0] ckeOut, ckeOe, csOut, csOe, rxEn, rdValidOut;
  logic initDone;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rank_pin_gate #(.NUM_RANKS(N)) dut_i (
    .clk(clk), .rstN(rstN), .initWr(initWr), .initWrData(initWrData),
    .popMask(popMask), .triEn(triEn), .rankIdle(rankIdle), .ckeReq(ckeReq),
    .csReq(csReq), .selfRefresh(selfRefresh), .rdValidIn(rdValidIn),
    .ckeOut(ckeOut), .ckeOe(ckeOe), .csOut(csOut), .csOe(csOe),
    .rxEn(rxEn), .rdValidOut(rdValidOut), .initDone(initDone)
  );

  // fields: pop, tri, idle, ckeReq, csReq, sr, rdvIn | oe, cke, cs, rx, rdvOut
  localparam logic [47:0] VEC [6] = '{
    48'hF_0_F_F_0_0_F_F_F_0_F_F,
    48'h5_0_F_A_3_0_F_F_A_3_F_F,
    48'h5_1_F_F_0_0_F_5_5_A_5_5,
    48'h5_1_F_F_0_1_F_5_0_A_5_5,
    48'hC_1_F_6_5_0_9_C_4_7_C_8,
    48'hF_1_F_3_C_0_F_F_3_C_F_F
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // Reset with hostile config: every rank still driven (R2), cke low (R1)
    popMask = '0; triEn = 1'b1; ckeReq = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "ckeOe in reset", {4'h0, ckeOe}, 8'h0F);
    chk("R2", "csOe in reset", {4'h0, csOe}, 8'h0F);
    chk("R2", "rxEn in reset", {4'h0, rxEn}, 8'h0F);
    chk("R1", "ckeOut in reset", {4'h0, ckeOut}, 8'h00);
    chk("R7", "initDone in reset", {7'h0, initDone}, 8'h00);
    @(negedge clk) rstN = 1'b1;
    tick();
    // Before init every edge captures: release applies (R4), cke still low (R1)
    chk("R4", "ckeOe released pre-init", {4'h0, ckeOe}, 8'h00);
    chk("R4", "csOut idle-high released", {4'h0, csOut}, 8'h0F);
    chk("R1", "ckeOut pre-init", {4'h0, ckeOut}, 8'h00);
    @(negedge clk) begin popMask = '1; triEn = 1'b0; end
    tick();
    chk("R1", "ckeOut driven pre-init", {4'h0, ckeOut}, 8'h00);
    chk("R9", "csOut follows req", {4'h0, csOut}, 8'h0F);

    // Release coincides with self-refresh (R6, R7)
    @(negedge clk) begin selfRefresh = 1'b1; initWr = 1'b1; initWrData = 1'b1; end
    tick();
    chk("R7", "initDone after write", {7'h0, initDone}, 8'h01);
    chk("R6", "ckeOut with sr at release", {4'h0, ckeOut}, 8'h00);
    @(negedge clk) begin initWr = 1'b0; selfRefresh = 1'b0; end
    #1;
    chk("R9", "ckeOut after sr drop", {4'h0, ckeOut}, 8'h0F);

    // Vector table (all ranks idle: capture each edge)
    foreach (VEC[i]) begin
      @(negedge clk) begin
        popMask = VEC[i][47:44]; triEn = VEC[i][40]; rankIdle = VEC[i][39:36];
        ckeReq = VEC[i][35:32]; csReq = VEC[i][31:28]; selfRefresh = VEC[i][24];
        rdValidIn = VEC[i][23:20];
      end
      tick();
      chk("R4", $sformatf("vec%0d ckeOe", i), {4'h0, ckeOe}, {4'h0, VEC[i][19:16]});
      chk("R4", $sformatf("vec%0d csOe", i), {4'h0, csOe}, {4'h0, VEC[i][19:16]});
      chk("R9", $sformatf("vec%0d ckeOut", i), {4'h0, ckeOut}, {4'h0, VEC[i][15:12]});
      chk("R9", $sformatf("vec%0d csOut", i), {4'h0, csOut}, {4'h0, VEC[i][11:8]});
      chk("R5", $sformatf("vec%0d rxEn", i), {4'h0, rxEn}, {4'h0, VEC[i][7:4]});
      chk("R5", $sformatf("vec%0d rdValidOut", i), {4'h0, rdValidOut}, {4'h0, VEC[i][3:0]});
    end
    // R3 vector (index 1) and R6 vector (index 3) are covered above

    // R8: rank 0 busy while ranks are declared unfitted
    @(negedge clk) begin popMask = '0; triEn = 1'b1; rankIdle = 4'hE; ckeReq = '1; end
    tick();
    chk("R8", "busy rank keeps drive", {4'h0, ckeOe}, 8'h01);
    @(negedge clk) begin popMask = '1; triEn = 1'b0; end
    tick();
    chk("R8", "busy rank ignores change", {4'h0, ckeOe}, 8'h0F & 8'h0F ^ 8'h00 & 8'h0F | 8'h00);
    @(negedge clk) begin popMask = '0; triEn = 1'b1; end
    tick();
    @(negedge clk) rankIdle = 4'hF;
    tick();
    chk("R8", "idle rank takes change", {4'h0, ckeOe}, 8'h00);
    chk("R4", "released cke low", {4'h0, ckeOut}, 8'h00);

    // R7: write of zero clears, then reset clears a set bit
    @(negedge clk) begin popMask = '1; triEn = 1'b0; initWr = 1'b1; initWrData = 1'b0; end
    tick();
    chk("R7", "initDone cleared by write", {7'h0, initDone}, 8'h00);
    chk("R1", "cke low after clear", {4'h0, ckeOut}, 8'h00);
    @(negedge clk) initWrData = 1'b1;
    tick();
    @(negedge clk) initWr = 1'b0;
    tick();
    chk("R7", "initDone holds", {7'h0, initDone}, 8'h01);
    @(negedge clk) rstN = 1'b0;
    #1;
    chk("R7", "initDone after reset", {7'h0, initDone}, 8'h00);
    chk("R1", "cke low in reset", {4'h0, ckeOut}, 8'h00);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule